// File: doc/BRIEF.md
# DDR3 Write Burst Data Scheduler

This block is the controller-side sequencer that turns one accepted WRITE request into a cycle-aligned double-data-rate beat stream. At the request it captures the column, the on-the-fly chop bit, the two-bit burst-length setting, the additive and CAS write latency settings, and an eight-slot buffer of data and mask beats indexed by column. After a write latency of AL + CWL clocks it raises a DQS preamble enable for one clock. It then presents two beats per clock, one on the rising and one on the falling edge, for two or four clocks, and raises a postamble enable for one clock. Delay tuning, strobe skew training, pads and the read path belong to other blocks.

A second WRITE that arrives while a burst is running is held in a one-entry slot. Its own latency keeps counting while it waits, and it starts at the later of its own latency point and the clock after the running postamble. While that slot is full, `busy` is high and further WRITEs are dropped. The settings must give AL + CWL of at least 2.

Control is one state machine. Its states are IDLE (nothing scheduled), WAIT (latency countdown), PRE (preamble clock), DATA (beat clocks) and POST (postamble clock). Its transitions are: accept (IDLE to WAIT, or POST to WAIT with nothing queued), expire (WAIT to PRE when the count reaches zero), tick (WAIT to WAIT while counting), open (PRE to DATA), beat (DATA to DATA), close (DATA to POST after the last beat clock), chain (POST to PRE or WAIT from the queued slot) and retire (POST to IDLE).

Top module: `wbs_top`

## Requirements
- R1: A WRITE sampled at clock edge a makes `dqs_pre_en` high after edge a+WL-1 for one clock, with WL = cfg_al + cfg_cwl. Data clocks follow from edge a+WL.
- R2: With cfg_bl 00 or 11, or with 01 and wr_a12 = 1, the burst has 4 data clocks (8 beats). With cfg_bl 10 it has 2 data clocks (4 beats), whatever wr_a12 is.
- R3: With cfg_bl 01 and wr_a12 = 0, the burst keeps 4 data clocks. Beats 4 to 7 drive DQ as zero and all DM bits as 1.
- R4: Beat j of a burst with column n comes from buffer slot (n+j) mod 8. Slot s sits in wr_data[s*DQ_W +: DQ_W] and wr_mask[s*DM_W +: DM_W]. Even beats appear on `dq_rise` and odd beats on `dq_fall`.
- R5: DM uses the beat timing of DQ. In every data clock, `dm_rise`/`dm_fall` carry the mask of the beat on `dq_rise`/`dq_fall`. DM_W = DQ_W/8, DM bit k covers DQ bits 8k+7..8k, and 1 means the lane is not written.
- R6: Outside data clocks, `data_oe` is low and dq_rise, dq_fall, dm_rise and dm_fall are all zero.
- R7: `dqs_pst_en` is high for exactly the one clock after the last data clock. Preamble, data and postamble enables are never high together.
- R8: A WRITE accepted while a burst is in WAIT, PRE or DATA is queued with its own settings. Its preamble comes at the later of edge a+WL-1 and the edge after the running postamble clock.
- R9: `busy` is high exactly while the queue slot is full. A WRITE sampled with `busy` high produces no burst.
- R10: After reset the block is idle, with all enables, beat outputs and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd | input | 1 | WRITE request strobe, one clock |
| wr_a12 | input | 1 | On-the-fly chop bit (1 = full burst) |
| wr_col | input | 3 | Starting column within the burst |
| wr_data | input | 8*DQ_W | Eight data beats indexed by column |
| wr_mask | input | 8*DM_W | Eight mask beats indexed by column |
| cfg_bl | input | 2 | Burst-length setting |
| cfg_al | input | LAT_W | Additive latency in clocks |
| cfg_cwl | input | LAT_W | CAS write latency in clocks |
| busy | output | 1 | Queue slot full, WRITE not accepted |
| dqs_pre_en | output | 1 | Strobe preamble clock |
| data_oe | output | 1 | Data clock, DQ and DM driven |
| dq_rise | output | DQ_W | Beat on the rising edge |
| dq_fall | output | DQ_W | Beat on the falling edge |
| dm_rise | output | DM_W | Mask for the rising beat |
| dm_fall | output | DM_W | Mask for the falling beat |
| dqs_pst_en | output | 1 | Strobe postamble clock |

## Verification
Single WRITEs are swept over all four burst-length settings, both chop-bit values, all eight start columns and three latency pairs, including the minimum WL of 2. This separates full, chopped-masked and short bursts, shows wraparound in column order, and shows the latency being the sum of the two settings. Each column buffer is filled from a seed-dependent formula, so a wrong slot, a swapped rising and falling lane or a mask that drifts by a beat gives a value the bench can see. Paired WRITEs are issued one clock apart, late enough that their own latency governs, exactly in the postamble clock, and with different settings. These cases tell queue ordering apart from latency tracking. A third WRITE sent while the slot is full must leave no trace at the outputs.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    localparam int BURST_SLOTS = 8;
    localparam int COL_W       = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_PRE,
        S_DATA,
        S_POST
    } wstate_e;

    // per-burst control captured at acceptance
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [1:0]       last_clk;   // index of the final data clock
        logic             trunc;      // beats 4..7 masked off
    } burst_ctl_t;

endpackage

// File: rtl/wbs_bl_decode.sv
module wbs_bl_decode (
    input  logic [1:0] bl_sel,
    input  logic       chop_n,
    output logic [1:0] last_clk,
    output logic       trunc
);
    always_comb begin
        unique case (bl_sel)
            2'b10: begin
                last_clk = 2'd1;
                trunc    = 1'b0;
            end
            2'b01: begin
                last_clk = 2'd3;
                trunc    = ~chop_n;
            end
            default: begin
                last_clk = 2'd3;
                trunc    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wbs_pend_slot.sv
module wbs_pend_slot
    import wbs_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int DM_W  = 2,
    parameter int CNT_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  burst_ctl_t                    ld_ctl,
    input  logic [CNT_W-1:0]              ld_wait,
    input  logic [BURST_SLOTS*DQ_W-1:0]   ld_data,
    input  logic [BURST_SLOTS*DM_W-1:0]   ld_mask,
    input  logic                          take,
    output logic                          vld,
    output burst_ctl_t                    ctl,
    output logic [CNT_W-1:0]              wait_q,
    output logic [BURST_SLOTS*DQ_W-1:0]   data,
    output logic [BURST_SLOTS*DM_W-1:0]   mask
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= 1'b0;
            ctl    <= '0;
            wait_q <= '0;
            data   <= '0;
            mask   <= '0;
        end else if (load) begin
            vld    <= 1'b1;
            ctl    <= ld_ctl;
            wait_q <= ld_wait;
            data   <= ld_data;
            mask   <= ld_mask;
        end else if (take) begin
            vld    <= 1'b0;
        end else if (vld && wait_q != '0) begin
            wait_q <= wait_q - 1'b1;   // own latency keeps running while queued
        end
    end

    // R9: a full slot is never overwritten
    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !vld);

    // R8: the state machine only drains a filled slot
    a_r8_take_valid: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> vld);

    // R8: a queued entry left alone keeps its contents
    a_r8_hold_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        vld && !take && !load |=> $stable(ctl));
endmodule

// File: rtl/wbs_beat_mux.sv
module wbs_beat_mux
    import wbs_pkg::*;
#(
    parameter int DQ_W = 16,
    parameter int DM_W = 2
) (
    input  logic [BURST_SLOTS*DQ_W-1:0] data,
    input  logic [BURST_SLOTS*DM_W-1:0] mask,
    input  logic [COL_W-1:0]            col,
    input  logic                        trunc,
    input  logic [1:0]                  beat_clk,
    input  logic                        active,
    output logic [DQ_W-1:0]             dq_rise,
    output logic [DQ_W-1:0]             dq_fall,
    output logic [DM_W-1:0]             dm_rise,
    output logic [DM_W-1:0]             dm_fall
);
    logic [DQ_W-1:0] dq_b [2];
    logic [DM_W-1:0] dm_b [2];

    for (genvar e = 0; e < 2; e++) begin : g_edge
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] slot;
        logic             masked;

        assign beat   = {beat_clk, 1'(e)};
        assign slot   = col + beat;              // wraps within the burst
        assign masked = trunc && beat[COL_W-1];

        always_comb begin
            if (!active) begin
                dq_b[e] = '0;
                dm_b[e] = '0;
            end else if (masked) begin
                dq_b[e] = '0;
                dm_b[e] = '1;
            end else begin
                dq_b[e] = data[int'(slot)*DQ_W +: DQ_W];
                dm_b[e] = mask[int'(slot)*DM_W +: DM_W];
            end
        end
    end

    assign dq_rise = dq_b[0];
    assign dq_fall = dq_b[1];
    assign dm_rise = dm_b[0];
    assign dm_fall = dm_b[1];
endmodule

// File: rtl/wbs_top.sv
module wbs_top
    import wbs_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int LAT_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_cmd,
    input  logic                            wr_a12,
    input  logic [2:0]                      wr_col,
    input  logic [8*DQ_W-1:0]               wr_data,
    input  logic [8*(DQ_W/8)-1:0]           wr_mask,
    input  logic [1:0]                      cfg_bl,
    input  logic [LAT_W-1:0]                cfg_al,
    input  logic [LAT_W-1:0]                cfg_cwl,
    output logic                            busy,
    output logic                            dqs_pre_en,
    output logic                            data_oe,
    output logic [DQ_W-1:0]                 dq_rise,
    output logic [DQ_W-1:0]                 dq_fall,
    output logic [DQ_W/8-1:0]               dm_rise,
    output logic [DQ_W/8-1:0]               dm_fall,
    output logic                            dqs_pst_en
);
    localparam int DM_W  = DQ_W / 8;
    localparam int CNT_W = LAT_W + 1;

    // ---------------- request decode ----------------
    logic [CNT_W-1:0] wl;
    logic [CNT_W-1:0] wl_m2;
    burst_ctl_t       cmd_ctl;

    assign wl    = CNT_W'(cfg_al) + CNT_W'(cfg_cwl);
    assign wl_m2 = wl - CNT_W'(2);

    wbs_bl_decode i_dec (
        .bl_sel   (cfg_bl),
        .chop_n   (wr_a12),
        .last_clk (cmd_ctl.last_clk),
        .trunc    (cmd_ctl.trunc)
    );
    assign cmd_ctl.col = wr_col;

    // ---------------- state ----------------
    wstate_e                    state_q, state_d;
    logic [CNT_W-1:0]           wcnt_q, wcnt_d;
    logic [1:0]                 bclk_q, bclk_d;
    burst_ctl_t                 act_ctl_q, act_ctl_d;
    logic [BURST_SLOTS*DQ_W-1:0] act_data_q, act_data_d;
    logic [BURST_SLOTS*DM_W-1:0] act_mask_q, act_mask_d;

    // queue slot
    logic                        pend_vld;
    burst_ctl_t                  pend_ctl;
    logic [CNT_W-1:0]            pend_wait;
    logic [BURST_SLOTS*DQ_W-1:0] pend_data;
    logic [BURST_SLOTS*DM_W-1:0] pend_mask;

    logic start_now, queue_now, launch_pend;

    assign start_now   = wr_cmd && !pend_vld &&
                         (state_q == S_IDLE || state_q == S_POST);
    assign queue_now   = wr_cmd && !pend_vld &&
                         (state_q inside {S_WAIT, S_PRE, S_DATA});
    assign launch_pend = (state_q == S_POST) && pend_vld;

    wbs_pend_slot #(.DQ_W(DQ_W), .DM_W(DM_W), .CNT_W(CNT_W)) i_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (queue_now),
        .ld_ctl  (cmd_ctl),
        .ld_wait (wl_m2),
        .ld_data (wr_data),
        .ld_mask (wr_mask),
        .take    (launch_pend),
        .vld     (pend_vld),
        .ctl     (pend_ctl),
        .wait_q  (pend_wait),
        .data    (pend_data),
        .mask    (pend_mask)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            wcnt_q     <= '0;
            bclk_q     <= '0;
            act_ctl_q  <= '0;
            act_data_q <= '0;
            act_mask_q <= '0;
        end else begin
            state_q    <= state_d;
            wcnt_q     <= wcnt_d;
            bclk_q     <= bclk_d;
            act_ctl_q  <= act_ctl_d;
            act_data_q <= act_data_d;
            act_mask_q <= act_mask_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d    = state_q;
        wcnt_d     = wcnt_q;
        bclk_d     = bclk_q;
        act_ctl_d  = act_ctl_q;
        act_data_d = act_data_q;
        act_mask_d = act_mask_q;

        if (start_now) begin
            act_ctl_d  = cmd_ctl;
            act_data_d = wr_data;
            act_mask_d = wr_mask;
        end else if (launch_pend) begin
            act_ctl_d  = pend_ctl;
            act_data_d = pend_data;
            act_mask_d = pend_mask;
        end

        unique case (state_q)
            S_IDLE: begin
                if (start_now) begin          // accept
                    state_d = S_WAIT;
                    wcnt_d  = wl_m2;
                end
            end
            S_WAIT: begin
                if (wcnt_q == '0) begin       // expire
                    state_d = S_PRE;
                end else begin                // tick
                    wcnt_d = wcnt_q - 1'b1;
                end
            end
            S_PRE: begin                      // open
                state_d = S_DATA;
                bclk_d  = '0;
            end
            S_DATA: begin
                if (bclk_q == act_ctl_q.last_clk) begin   // close
                    state_d = S_POST;
                end else begin                            // beat
                    bclk_d = bclk_q + 1'b1;
                end
            end
            S_POST: begin
                if (launch_pend) begin        // chain
                    if (pend_wait == '0) begin
                        state_d = S_PRE;
                    end else begin
                        state_d = S_WAIT;
                        wcnt_d  = pend_wait - 1'b1;
                    end
                end else if (start_now) begin // accept
                    state_d = S_WAIT;
                    wcnt_d  = wl_m2;
                end else begin                // retire
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy       = pend_vld;
        dqs_pre_en = (state_q == S_PRE);
        data_oe    = (state_q == S_DATA);
        dqs_pst_en = (state_q == S_POST);
    end

    wbs_beat_mux #(.DQ_W(DQ_W), .DM_W(DM_W)) i_mux (
        .data     (act_data_q),
        .mask     (act_mask_q),
        .col      (act_ctl_q.col),
        .trunc    (act_ctl_q.trunc),
        .beat_clk (bclk_q),
        .active   (data_oe),
        .dq_rise  (dq_rise),
        .dq_fall  (dq_fall),
        .dm_rise  (dm_rise),
        .dm_fall  (dm_fall)
    );

    // ---------------- assertions ----------------
    // R1: latency setting must leave room for the preamble clock
    a_r1_wl_min: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |-> wl >= CNT_W'(2));

    // R1: the preamble clock is followed by data
    a_r1_pre_to_data: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pre_en |=> data_oe);

    // R7: data ends into a postamble
    a_r7_post_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_oe) |-> dqs_pst_en);

    // R7: postamble lasts one clock
    a_r7_post_single: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pst_en |=> !dqs_pst_en);

    // R7: phases never overlap
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dqs_pre_en, data_oe, dqs_pst_en}));

    // R6: lanes quiet outside data clocks
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (dq_rise == '0 && dq_fall == '0 &&
                      dm_rise == '0 && dm_fall == '0));

    // R3: chopped tail is fully masked
    a_r3_chop_mask: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe && act_ctl_q.trunc && bclk_q[1] |-> (&dm_rise && &dm_fall));

    // R2: a short burst never reaches the third data clock
    a_r2_short_len: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe && act_ctl_q.last_clk == 2'd1 |-> !bclk_q[1]);
endmodule

// File: tb/test_wbs_top.sv
module test_wbs_top;
    localparam int DQ_W  = 16;
    localparam int DM_W  = DQ_W / 8;
    localparam int LAT_W = 4;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  wr_cmd;
    logic                  wr_a12;
    logic [2:0]            wr_col;
    logic [8*DQ_W-1:0]     wr_data;
    logic [8*DM_W-1:0]     wr_mask;
    logic [1:0]            cfg_bl;
    logic [LAT_W-1:0]      cfg_al;
    logic [LAT_W-1:0]      cfg_cwl;
    logic                  busy, dqs_pre_en, data_oe, dqs_pst_en;
    logic [DQ_W-1:0]       dq_rise, dq_fall;
    logic [DM_W-1:0]       dm_rise, dm_fall;

    always #2 clk = ~clk;   // 250 MHz

    wbs_top #(.DQ_W(DQ_W), .LAT_W(LAT_W)) i_wbs_top (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_a12(wr_a12),
        .wr_col(wr_col), .wr_data(wr_data), .wr_mask(wr_mask),
        .cfg_bl(cfg_bl), .cfg_al(cfg_al), .cfg_cwl(cfg_cwl),
        .busy(busy), .dqs_pre_en(dqs_pre_en), .data_oe(data_oe),
        .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise),
        .dm_fall(dm_fall), .dqs_pst_en(dqs_pst_en)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // scoreboard of recorded bursts
    int              nb;
    int              acc [3];
    int              pre [3];
    int              ncl [3];
    int              lch [3];
    bit              qd  [3];
    bit              trc [3];
    int              bcol[3];
    logic [8*DQ_W-1:0] bdat[3];
    logic [8*DM_W-1:0] bmsk[3];

    task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at edge %0d act=%0h exp=%0h", what, cyc, act, exp);
        end
    endtask

    function automatic logic [DQ_W-1:0] pat_dq(int seed, int s);
        return DQ_W'(seed * 16'h0137 + s * 16'h1009 + 16'h5a00);
    endfunction

    function automatic logic [DM_W-1:0] pat_dm(int seed, int s);
        return DM_W'(seed + s);
    endfunction

    task automatic check_now(string tag);
        int e = cyc;
        logic e_pre = 0, e_oe = 0, e_pst = 0, e_busy = 0;
        logic [DQ_W-1:0] e_dq [2];
        logic [DM_W-1:0] e_dm [2];
        e_dq[0] = '0; e_dq[1] = '0; e_dm[0] = '0; e_dm[1] = '0;
        for (int b = 0; b < nb; b++) begin
            if (e == pre[b]) e_pre = 1;
            if (e == pre[b] + ncl[b] + 1) e_pst = 1;
            if (qd[b] && e >= acc[b] && e < lch[b]) e_busy = 1;
            if (e > pre[b] && e <= pre[b] + ncl[b]) begin
                e_oe = 1;
                for (int h = 0; h < 2; h++) begin
                    int j    = 2 * (e - pre[b] - 1) + h;
                    int slot = (bcol[b] + j) % 8;
                    if (trc[b] && j >= 4) begin
                        e_dq[h] = '0;
                        e_dm[h] = '1;
                    end else begin
                        e_dq[h] = bdat[b][slot*DQ_W +: DQ_W];
                        e_dm[h] = bmsk[b][slot*DM_W +: DM_W];
                    end
                end
            end
        end
        chk({dqs_pre_en, data_oe, dqs_pst_en} == {e_pre, e_oe, e_pst},
            {tag, " R7 phase enables"}, 64'({dqs_pre_en, data_oe, dqs_pst_en}),
            64'({e_pre, e_oe, e_pst}));
        chk({dq_rise, dq_fall} == {e_dq[0], e_dq[1]}, {tag, " R4 R3 data beats"},
            64'({dq_rise, dq_fall}), 64'({e_dq[0], e_dq[1]}));
        chk({dm_rise, dm_fall} == {e_dm[0], e_dm[1]},
            e_oe ? {tag, " R5 R3 mask beats"} : {tag, " R6 quiet mask"},
            64'({dm_rise, dm_fall}), 64'({e_dm[0], e_dm[1]}));
        chk(busy == e_busy, {tag, " R9 busy"}, 64'(busy), 64'(e_busy));
    endtask

    task automatic step(string tag);
        @(negedge clk);
        wr_cmd = 1'b0;
        check_now(tag);
    endtask

    task automatic issue(int mode, bit a12, int col, int al, int cwl, int seed, bit rec);
        wr_cmd  = 1'b1;
        wr_a12  = a12;
        wr_col  = 3'(col);
        cfg_bl  = 2'(mode);
        cfg_al  = LAT_W'(al);
        cfg_cwl = LAT_W'(cwl);
        for (int s = 0; s < 8; s++) begin
            wr_data[s*DQ_W +: DQ_W] = pat_dq(seed, s);
            wr_mask[s*DM_W +: DM_W] = pat_dm(seed, s);
        end
        if (rec) begin
            int b   = nb;
            int own;
            acc[b]  = cyc + 1;
            own     = acc[b] + al + cwl - 1;
            ncl[b]  = (mode == 2) ? 2 : 4;
            trc[b]  = (mode == 1) && !a12;
            bcol[b] = col;
            bdat[b] = wr_data;
            bmsk[b] = wr_mask;
            qd[b]   = 1'b0;
            lch[b]  = 0;
            pre[b]  = own;
            if (b > 0) begin
                int l = pre[b-1] + ncl[b-1] + 2;
                qd[b]  = acc[b] < l;
                lch[b] = l;
                pre[b] = (own > l) ? own : l;
            end
            nb++;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at edge %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int al_t [3] = '{0, 3, 0};
        int cwl_t[3] = '{5, 6, 2};
        nb = 0;
        rst_n = 1'b0; wr_cmd = 1'b0; wr_a12 = 1'b0; wr_col = '0;
        wr_data = '0; wr_mask = '0; cfg_bl = '0; cfg_al = '0; cfg_cwl = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) step("R10 reset");

        // single bursts: all settings, chop bit, columns, latencies (R1 R2 R3 R4 R5)
        for (int m = 0; m < 4; m++)
            for (int a = 0; a < 2; a++)
                for (int c = 0; c < 8; c++)
                    for (int k = 0; k < 3; k++) begin
                        nb = 0;
                        issue(m, a[0], c, al_t[k], cwl_t[k], m * 31 + c * 7 + k + a, 1'b1);
                        repeat (al_t[k] + cwl_t[k] + 8) step("R1 R2");
                    end

        // back-to-back, third request while busy is dropped (R8 R9)
        nb = 0;
        issue(0, 1'b1, 3, 0, 5, 11, 1'b1); step("R8");
        issue(0, 1'b1, 6, 0, 5, 12, 1'b1); step("R8");
        issue(0, 1'b1, 1, 0, 5, 13, 1'b0); step("R9 ignored");
        repeat (25) step("R9 ignored");

        // queued but own latency governs (R8)
        nb = 0;
        issue(0, 1'b1, 0, 0, 5, 21, 1'b1); step("R8");
        repeat (6) step("R8");
        issue(1, 1'b0, 5, 0, 5, 22, 1'b1); step("R8 late");
        repeat (20) step("R8 late");

        // request in the postamble clock starts directly (R8)
        nb = 0;
        issue(0, 1'b1, 2, 0, 5, 31, 1'b1); step("R8");
        repeat (9) step("R8");
        issue(2, 1'b0, 7, 0, 5, 32, 1'b1); step("R8 post");
        repeat (20) step("R8 post");

        // queued with different latency and length (R8 R2 R3)
        nb = 0;
        issue(1, 1'b0, 4, 0, 5, 41, 1'b1); step("R8");
        step("R8");
        issue(2, 1'b1, 6, 3, 6, 42, 1'b1); step("R8 mixed");
        repeat (25) step("R8 mixed");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule